// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Gray Back End

This block is the digital tail of a flash analog-to-digital converter. Each clock it captures one thermometer word, with one bit per comparator, into an input register. An OR network then repairs a single zero bubble, meaning a comparator that reads low while comparators above it read high. The block counts the ones in the repaired word and maps that count to a reflected Gray code. A second register holds the result as the converter's primary output.

The Gray output limits the damage of a wrong output bit. Neighbouring levels differ in exactly one bit, so a single flipped bit near a level boundary moves the result by about one step. The pipeline has a fixed depth of two registers. A parameter can append further output registers so that this path lines up with other paths in the chip. Every register clears to zero on a synchronous reset.

Top module: `tg_flash_backend`

## Requirements
- R1: Take an input that holds k ones in bits 0..k-1 and zeros above, for k from 0 to 15. Two cycles later the output shows the Gray code of k.
- R2: A clean thermometer word passes the OR network unchanged. A word that is a clean level k with a single bit m cleared, where m is at most k-2, produces the same output as the clean level k.
- R3: For a level k, the output code is k XOR (k >> 1). The codes of levels k-1 and k differ in exactly one bit.
- R4: A new input can be applied on every clock. The output for the input captured at edge n appears after edge n+1, and no earlier or later.
- R5: The reset is synchronous and active high, and it clears the input, encode and delay registers. The output is 0 while reset is held, whatever the input. It is still 0 in the first cycle after reset is released.
- R6: For any 15-bit input t, the repaired bit i (counting from 0) is t[i] | t[i+1] for i from 0 to 13, and bit 14 is t[14]. The output is the Gray code of the number of ones in the repaired word.
- R7: With EXTRA_STAGES = e, the output is the same code stream delayed by 2 + e cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| therm_i | input | THERM_W (15) | Comparator decisions, bit 0 lowest threshold |
| gray_o | output | OUT_W (4) | Registered Gray-coded conversion result |

## Verification
A sweep of the sixteen clean levels, each held for three cycles, checks the Gray mapping and the one-bit step between neighbouring levels. Each of the 105 single-bubble words is then applied back to back, so one run checks both the repair and the two-cycle latency without gaps. Uniformly random words exercise the OR rule on multi-bubble and stray-bit inputs, where the repaired level differs from a plain count of ones. The stream continues through a reset applied mid-stream, and a second instance with one extra stage shows that the delay option shifts the stream by exactly one cycle.

// File: rtl/tg_flash_pkg.sv
package tg_flash_pkg;

   // Reflected Gray code of an unsigned value
   function automatic logic [31:0] tg_bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

endpackage

// File: rtl/tg_pipe_reg.sv
module tg_pipe_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/tg_bubble_or.sv
module tg_bubble_or #(
   parameter int W = 15
) (
   input  logic [W-1:0] therm_i,
   output logic [W-1:0] clean_o
);

   genvar gi;
   generate
      for (gi = 0; gi < W - 1; gi++) begin : g_or
         assign clean_o[gi] = therm_i[gi] | therm_i[gi+1];
      end
   endgenerate
   assign clean_o[W-1] = therm_i[W-1];

   // a word of the form 0..01..1 must leave the network untouched
   logic [W-1:0] therm_inc;
   assign therm_inc = therm_i + 1'b1;

   always_comb begin
      if ((therm_i & therm_inc) == '0)
         p_clean_kept_r2: assert (clean_o == therm_i)
            else $error("clean thermometer word altered by bubble network");
   end

endmodule

// File: rtl/tg_gray_enc.sv
module tg_gray_enc
   import tg_flash_pkg::*;
#(
   parameter int W     = 15,
   parameter int OUT_W = 4
) (
   input  logic [W-1:0]     clean_i,
   output logic [OUT_W-1:0] gray_o
);

   logic [OUT_W-1:0] level;

   always_comb begin
      level = '0;
      for (int i = 0; i < W; i++)
         level = level + OUT_W'(clean_i[i]);
   end

   assign gray_o = OUT_W'(tg_bin2gray(32'(level)));

   // parity of a Gray code word equals the LSB of the value it encodes
   always_comb begin
      p_gray_parity_r3: assert ((^gray_o) == level[0])
         else $error("gray parity does not match level LSB");
   end

endmodule

// File: rtl/tg_flash_backend.sv
module tg_flash_backend #(
   parameter int THERM_W      = 15,
   parameter int EXTRA_STAGES = 0,
   localparam int OUT_W       = $clog2(THERM_W + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [THERM_W-1:0] therm_i,
   output logic [OUT_W-1:0]   gray_o
);

   generate
      if (THERM_W < 3) begin : g_chk_w
         $error("THERM_W must be at least 3");
      end
      if (((THERM_W + 1) & THERM_W) != 0) begin : g_chk_pow
         $error("THERM_W + 1 must be a power of two");
      end
      if (EXTRA_STAGES < 0) begin : g_chk_dly
         $error("EXTRA_STAGES must not be negative");
      end
   endgenerate

   logic [THERM_W-1:0] therm_q;
   logic [THERM_W-1:0] clean;
   logic [OUT_W-1:0]   gray_d;
   logic [OUT_W-1:0]   gray_q;

   tg_pipe_reg #(.W(THERM_W)) u_cap (
      .clk(clk), .rst(rst), .d(therm_i), .q(therm_q)
   );

   tg_bubble_or #(.W(THERM_W)) u_or (
      .therm_i(therm_q), .clean_o(clean)
   );

   tg_gray_enc #(.W(THERM_W), .OUT_W(OUT_W)) u_enc (
      .clean_i(clean), .gray_o(gray_d)
   );

   tg_pipe_reg #(.W(OUT_W)) u_out (
      .clk(clk), .rst(rst), .d(gray_d), .q(gray_q)
   );

   // optional delay-matching registers behind the encode stage
   logic [OUT_W-1:0] dly [0:EXTRA_STAGES];
   assign dly[0] = gray_q;

   genvar gi;
   generate
      for (gi = 0; gi < EXTRA_STAGES; gi++) begin : g_dly
         tg_pipe_reg #(.W(OUT_W)) u_dly (
            .clk(clk), .rst(rst), .d(dly[gi]), .q(dly[gi+1])
         );
      end
   endgenerate

   assign gray_o = dly[EXTRA_STAGES];

   p_reset_clears_r5: assert property (@(posedge clk)
      rst |=> (gray_o == '0))
      else $error("output not cleared by reset");

   p_enc_stage_r4: assert property (@(posedge clk) disable iff (rst)
      $stable(therm_q) |=> $stable(gray_q))
      else $error("encode register changed without a change in captured input");

endmodule

// File: tb/test_tg_flash_backend.sv
module test_tg_flash_backend;

   localparam int TW = 15;
   localparam int GW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [TW-1:0] therm = '0;
   logic [GW-1:0] gray_o;
   logic [GW-1:0] gray_dly;

   int tests = 0;
   int fails = 0;

   logic [GW-1:0] hist [0:2];
   logic [GW-1:0] last_sample;

   always #10 clk = ~clk;

   tg_flash_backend i_tg_flash_backend (
      .clk(clk), .rst(rst), .therm_i(therm), .gray_o(gray_o)
   );

   tg_flash_backend #(.EXTRA_STAGES(1)) i_tg_flash_backend_dly (
      .clk(clk), .rst(rst), .therm_i(therm), .gray_o(gray_dly)
   );

   // expected output from the stated repair and encoding rules
   function automatic logic [GW-1:0] exp_gray(input logic [TW-1:0] t);
      logic [TW-1:0] c;
      int n;
      for (int j = 0; j < TW - 1; j++) c[j] = t[j] | t[j+1];
      c[TW-1] = t[TW-1];
      n = $countones(c);
      return GW'(n ^ (n >> 1));
   endfunction

   function automatic logic [TW-1:0] level_word(input int k);
      return TW'((32'd1 << k) - 1);
   endfunction

   task automatic check(input logic [GW-1:0] got, input logic [GW-1:0] exp,
                        input string tag);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // one clock: check outputs against history, then drive the next input
   task automatic step(input logic r, input logic [TW-1:0] t, input string tag);
      @(negedge clk);
      last_sample = gray_o;
      check(gray_o, hist[1], tag);
      check(gray_dly, hist[2], "R7 delayed instance");
      rst   = r;
      therm = t;
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = r ? '0 : exp_gray(t);
      if (r) begin
         hist[1] = '0;
         hist[2] = '0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [GW-1:0] prev;
      prev = '0;
      hist[0] = '0; hist[1] = '0; hist[2] = '0;
      void'($urandom(32'd20240611));

      // R5: held reset with all comparators high keeps output at zero
      for (int i = 0; i < 3; i++) step(1'b1, '1, "R5 reset held");

      // R1 / R3 sweep of clean levels; release of reset happens on the first
      for (int k = 0; k <= TW; k++) begin
         for (int h = 0; h < 3; h++) step(1'b0, level_word(k), "R1 R4 clean level");
         check(last_sample, GW'(k ^ (k >> 1)), "R3 gray encoding");
         if (k > 0) begin
            tests++;
            if ($countones(last_sample ^ prev) != 1) begin
               fails++;
               $display("FAIL R3 adjacent step: got %h expected one-bit change from %h",
                        last_sample, prev);
            end
         end
         prev = last_sample;
      end

      // R2: every single bubble below the top one, back to back
      for (int k = 2; k <= TW; k++)
         for (int m = 0; m <= k - 2; m++)
            step(1'b0, level_word(k) & ~TW'(32'd1 << m), "R2 R4 single bubble");

      // R6: random words, with a reset pulse inside the stream
      for (int i = 0; i < 200; i++) step(1'b0, TW'($urandom), "R6 R4 random");
      step(1'b1, TW'($urandom), "R5 reset mid-stream");
      for (int i = 0; i < 200; i++) step(1'b0, TW'($urandom), "R6 R5 after reset");

      // random clean levels with one random bubble
      for (int i = 0; i < 100; i++) begin
         int k;
         int m;
         k = 2 + int'($urandom % 14);
         m = int'($urandom % (k - 1));
         step(1'b0, level_word(k) & ~TW'(32'd1 << m), "R2 random bubble");
      end

      for (int i = 0; i < 3; i++) step(1'b0, '0, "R1 flush");
      finish_run();
   end

endmodule